// File: doc/BRIEF.md
# Packed Colour Lookup Table with RGB Expansion

This block keeps a 256-entry colour lookup table for a display pipeline. Storage is 128 words of 32 bits. Each word carries two 16-bit entries: the even entry sits in the low halfword and the odd entry in the high halfword. Each entry packs three 5-bit colour channels and one intensity bit. Software fills and inspects the table through a simple word-wide register bus. The bus decodes a window of 128 word addresses, and a read always returns the raw word exactly as it was last written.

The pixel path is a valid/ready stream. An 8-bit pixel index enters the block. One cycle later an expanded 24-bit RGB value leaves it, with each 5-bit channel widened to 8 bits by appending three zero bits. The intensity bit plays no part in the colour. The block accepts an index when `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the output register is empty or the consumer is taking the current pixel. When `px_valid` is high and `px_ready` is low, the output pixel stays frozen and no new index is accepted. The bus has no back-pressure. A read answers on the following cycle.

Top module: `pal_lut_top`

## Requirements
- R1: A bus write (`bus_en`=1, `bus_we`=1) to a window address stores the 32-bit data. A bus read (`bus_en`=1, `bus_we`=0) raises `bus_rvalid` for exactly one cycle, on the next cycle, and `bus_rdata` then holds the raw stored word.
- R2: The window covers byte addresses 0x200 to 0x3FC, and word n sits at 0x200+4n. Bits [1:0] of the address are ignored. A write outside the window changes no word. A read outside the window returns 0.
- R3: Pixel index i reads word i[7:1]. When i[0]=0 the entry comes from bits [15:0] of that word, and when i[0]=1 it comes from bits [31:16].
- R4: In an entry, red is in bits [4:0], green in bits [9:5] and blue in bits [14:10]. `px_rgb` is {red,3'b000, green,3'b000, blue,3'b000}, with red in bits [23:16] and blue in bits [7:0].
- R5: Bit 15 of an entry has no effect on `px_rgb`.
- R6: An index accepted in one cycle gives `px_valid`=1 with its colour on the next cycle.
- R7: While `px_valid`=1 and `px_ready`=0, `px_rgb` and `px_valid` hold and `lk_ready` is 0. Otherwise `lk_ready` is 1, and `px_valid` falls when it is consumed with no new index accepted.
- R8: When a bus write and an accepted lookup address the same word in the same cycle, the lookup returns the word's previous contents.
- R9: Reset (`rst_n`=0) clears every word to 0 and drives `px_valid` and `bus_rvalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| lk_valid | input | 1 | Pixel index valid |
| lk_ready | output | 1 | Block can accept a pixel index |
| lk_index | input | 8 | Pixel index |
| px_valid | output | 1 | Expanded colour valid |
| px_ready | input | 1 | Consumer takes the colour |
| px_rgb | output | 24 | Expanded colour {R,G,B} |

## Verification
The bus write port and the pixel lookup can hit the same storage word in the same clock cycle. The bench provokes this in a directed case, writing a word while looking up one of its two entries. It also provokes it continuously in random traffic that confines both the bus and the pixel indices to a handful of words. In both cases the behavioural model reads its table before applying the write, so each lookup must return the colour held before that cycle's write.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int ENTRY_W = 16;
  localparam int WORD_W  = 2 * ENTRY_W;
  localparam int CH_W    = 5;
  localparam int OUT_W   = 8;
  localparam int PAD_W   = OUT_W - CH_W;

  typedef struct packed {
    logic [OUT_W-1:0] red;
    logic [OUT_W-1:0] green;
    logic [OUT_W-1:0] blue;
  } rgb_t;

  typedef struct packed {
    logic            intensity;
    logic [CH_W-1:0] blue;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] red;
  } entry_t;

  function automatic rgb_t widen_entry(input entry_t e);
    rgb_t c;
    c.red   = {e.red,   {PAD_W{1'b0}}};
    c.green = {e.green, {PAD_W{1'b0}}};
    c.blue  = {e.blue,  {PAD_W{1'b0}}};
    return c;
  endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WIDX_W-1:0] rd_idx_a,
  output logic [WORD_W-1:0] rd_data_a,
  input  logic [WIDX_W-1:0] rd_idx_b,
  output logic [WORD_W-1:0] rd_data_b
);

  logic [WORD_W-1:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) cells[k] <= '0;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = cells[rd_idx_a];
  assign rd_data_b = cells[rd_idx_b];

  // R1: a write lands in the addressed word
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/pal_bus_port.sv
module pal_bus_port #(
  parameter int                ADDR_W = 12,
  parameter int                WORDS  = 128,
  parameter int                WORD_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 12'h200,
  localparam int               WIDX_W = $clog2(WORDS),
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(int'(BASE) + WORDS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              st_wr_en,
  output logic [WIDX_W-1:0] st_idx,
  output logic [WORD_W-1:0] st_wdata,
  input  logic [WORD_W-1:0] st_rdata
);

  logic              in_win;
  logic [ADDR_W-1:0] offset;
  logic              unused_bits;

  assign in_win      = (bus_addr >= BASE) && (bus_addr < LIMIT);
  assign offset      = bus_addr - BASE;
  assign st_idx      = offset[WIDX_W+1:2];
  assign unused_bits = ^{offset[1:0], offset[ADDR_W-1:WIDX_W+2]};
  assign st_wr_en    = bus_en && bus_we && in_win;
  assign st_wdata    = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      if (bus_en && !bus_we) bus_rdata <= in_win ? st_rdata : '0;
    end
  end

  p_read_answers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid);
  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !in_win) |=> bus_rdata == '0);

endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int  IDX_W  = 8,
  localparam int WIDX_W = IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [3*OUT_W-1:0] px_rgb,
  output logic [WIDX_W-1:0] st_idx,
  input  logic [WORD_W-1:0] st_rdata
);

  logic [ENTRY_W-1:0] halves [2];
  entry_t             held_q;
  logic               take;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = st_rdata[h*ENTRY_W +: ENTRY_W];
  end

  assign st_idx   = lk_index[IDX_W-1:1];
  assign lk_ready = !px_valid || px_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_valid <= 1'b0;
      held_q   <= '0;
    end else if (take) begin
      px_valid <= 1'b1;
      held_q   <= entry_t'(halves[lk_index[0]]);
    end else if (px_ready) begin
      px_valid <= 1'b0;
    end
  end

  assign px_rgb = widen_entry(held_q);

  p_accept_gives_pixel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> px_valid);
  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_rgb)));
  p_consumed_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready && !lk_valid) |=> !px_valid);

endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
  import pal_pkg::*;
#(
  parameter int                ENTRIES  = 256,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200,
  localparam int               IDX_W    = $clog2(ENTRIES),
  localparam int               WORDS    = ENTRIES / 2,
  localparam int               WIDX_W   = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic [IDX_W-1:0]     lk_index,
  output logic                 px_valid,
  input  logic                 px_ready,
  output logic [3*OUT_W-1:0]   px_rgb
);

  logic              wr_en;
  logic [WIDX_W-1:0] bus_idx;
  logic [WIDX_W-1:0] pix_idx;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] bus_word;
  logic [WORD_W-1:0] pix_word;

  pal_bus_port #(
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS),
    .WORD_W (WORD_W),
    .BASE   (WIN_BASE)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .st_wr_en   (wr_en),
    .st_idx     (bus_idx),
    .st_wdata   (wr_data),
    .st_rdata   (bus_word)
  );

  pal_store #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (bus_idx),
    .wr_data   (wr_data),
    .rd_idx_a  (bus_idx),
    .rd_data_a (bus_word),
    .rd_idx_b  (pix_idx),
    .rd_data_b (pix_word)
  );

  pal_lookup #(
    .IDX_W (IDX_W)
  ) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_index (lk_index),
    .px_valid (px_valid),
    .px_ready (px_ready),
    .px_rgb   (px_rgb),
    .st_idx   (pix_idx),
    .st_rdata (pix_word)
  );

  // R9: outputs quiet straight after reset release
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!px_valid && !bus_rvalid));

endmodule

// File: tb/pal_lut_top_tb.sv
module pal_lut_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        lk_valid = 1'b0, lk_ready;
  logic [7:0]  lk_index = '0;
  logic        px_valid, px_ready = 1'b1;
  logic [23:0] px_rgb;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pal_lut_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_index(lk_index), .px_valid(px_valid), .px_ready(px_ready),
    .px_rgb(px_rgb)
  );

  // behavioural reference
  logic [31:0] model [128];
  logic        m_rvalid, m_pv;
  logic [31:0] m_rdata;
  logic [23:0] m_rgb;

  function automatic logic [23:0] colour_of(input logic [15:0] e);
    int r, g, b;
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  function automatic bit in_window(input logic [11:0] a);
    return (a >= 12'h200) && (a < 12'h400);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) model[k] = '0;
      m_rvalid = 0; m_pv = 0; m_rdata = '0; m_rgb = '0;
    end else begin
      logic        rdy;
      logic [31:0] w;
      int          wi;
      rdy = !m_pv || px_ready;
      if (lk_valid && rdy) begin
        w = model[lk_index / 2];
        m_rgb = colour_of(lk_index[0] ? w[31:16] : w[15:0]);
        m_pv = 1;
      end else if (px_ready) m_pv = 0;
      wi = (int'(bus_addr) - 'h200) / 4;
      m_rvalid = bus_en && !bus_we;
      if (bus_en && !bus_we) m_rdata = in_window(bus_addr) ? model[wi] : 32'h0;
      if (bus_en && bus_we && in_window(bus_addr)) model[wi] = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 rvalid", 32'(bus_rvalid), 32'(m_rvalid));
      if (m_rvalid) chk("R1/R2 rdata", bus_rdata, m_rdata);
      chk("R6 px_valid", 32'(px_valid), 32'(m_pv));
      if (m_pv) chk("R3/R4 px_rgb", 32'(px_rgb), 32'(m_rgb));
      chk("R7 lk_ready", 32'(lk_ready), 32'(!m_pv || px_ready));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step(); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] e);
    step(); bus_en = 1; bus_we = 0; bus_addr = a;
    step(); bus_en = 0;
    @(negedge clk); chk(tag, bus_rdata, e);
  endtask

  task automatic lk_chk(input string tag, input logic [7:0] i, input logic [23:0] e);
    step(); lk_valid = 1; lk_index = i;
    step(); lk_valid = 0;
    @(negedge clk);
    chk({tag, " valid"}, 32'(px_valid), 32'd1);
    chk(tag, 32'(px_rgb), 32'(e));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R9 px_valid after reset", 32'(px_valid), 0);
    chk("R9 rvalid after reset", 32'(bus_rvalid), 0);
    lk_chk("R9 cleared entry", 8'd5, 24'h0);

    wr(12'h200, 32'h7C00_801F);
    rd_chk("R1 raw word", 12'h200, 32'h7C00_801F);
    lk_chk("R4 R5 red with intensity", 8'd0, 24'hF8_0000);
    lk_chk("R3 odd entry high half", 8'd1, 24'h00_00F8);

    wr(12'h3FC, 32'h03E0_1234);
    rd_chk("R2 last word", 12'h3FF, 32'h03E0_1234);
    lk_chk("R3 index 255", 8'd255, 24'h00_F800);
    lk_chk("R4 mixed channels", 8'd254, 24'hA0_8820);

    wr(12'h400, 32'hDEAD_BEEF);
    wr(12'h1FC, 32'hCAFE_F00D);
    rd_chk("R2 outside read zero", 12'h400, 32'h0);
    rd_chk("R2 below window zero", 12'h1FC, 32'h0);
    rd_chk("R2 no alias write", 12'h200, 32'h7C00_801F);

    step(); bus_en = 1; bus_we = 1; bus_addr = 12'h20C; bus_wdata = 32'hFFFF_FFFF;
    lk_valid = 1; lk_index = 8'd6;
    step(); bus_en = 0; bus_we = 0; lk_valid = 0;
    @(negedge clk); chk("R8 same-cycle old data", 32'(px_rgb), 32'h0);
    lk_chk("R8 R5 new data after", 8'd7, 24'hF8_F8F8);

    step(); px_ready = 0; lk_valid = 1; lk_index = 8'd0;
    step(); lk_index = 8'd1;
    step(); step(); step();
    @(negedge clk);
    chk("R7 stalled colour held", 32'(px_rgb), 32'hF8_0000);
    chk("R7 ready low in stall", 32'(lk_ready), 0);
    step(); px_ready = 1;
    step(); lk_valid = 0;
    @(negedge clk);
    chk("R7 next after release", 32'(px_rgb), 32'h00_00F8);
    chk("R6 valid after release", 32'(px_valid), 1);

    for (int n = 0; n < 4000; n++) begin
      step();
      bus_en = ($urandom_range(0, 2) != 0);
      bus_we = $urandom_range(0, 1);
      if ($urandom_range(0, 4) == 0) bus_addr = 12'($urandom_range(0, 1023) * 4 + $urandom_range(0, 3));
      else bus_addr = 12'h200 + 12'($urandom_range(0, 3) * 4);
      bus_wdata = $urandom;
      lk_valid = $urandom_range(0, 1);
      lk_index = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) lk_index = 8'($urandom);
      px_ready = ($urandom_range(0, 3) != 0);
    end
    step(); bus_en = 0; lk_valid = 0; px_ready = 1;
    repeat (3) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule